// File: doc/BRIEF.md
# Shadow-Backed SRAM with Address-Sequence Store/Recall

This block is a byte-wide static memory in which every word has a companion nonvolatile shadow word. In normal operation it behaves as a plain SRAM behind a synchronous chip-enable / output-enable / write-enable port. A nonvolatile transfer is started by issuing six reads in a row at fixed key addresses on that same port. The last address of the six picks the direction. A save copies every SRAM word into the shadow array. A restore first zeroes the SRAM and then loads it from the shadow array.

A restore also starts by itself when reset is released, which stands in for power-up. While a transfer runs, `busy` is high, reads return nothing and writes are dropped. The transfer walks one address per clock, so its length is set by the array depth plus a parameterised settle tail for saves.

Two state machines make up the block. The key matcher has the states MS_A, MS_B, MS_C, MS_D, MS_E and MS_F. A key read at the expected address advances it A→B→C→D→E→F. The sixth read returns it from F to A and fires a save or a restore. A write or a wrong-address read also returns it to A. The transfer controller has the states XF_IDLE, XF_STORE_WALK, XF_STORE_SETTLE, XF_RCL_CLEAR and XF_RCL_LOAD. Its transitions are:
- IDLE→STORE_WALK on a save trigger.
- IDLE→RCL_CLEAR on a restore trigger, and from reset.
- STORE_WALK→STORE_SETTLE at the last address.
- STORE_SETTLE→IDLE after the tail.
- RCL_CLEAR→RCL_LOAD at the last address.
- RCL_LOAD→IDLE at the last address.

Top module: `nv_shadow_mem`

## Requirements
- R1: When `busy` is low, a read (`ce`=1, `oe`=1, `we`=0) sampled at a clock edge drives that word on `rdata` with `rvalid`=1 after that edge. A write (`ce`=1, `we`=1, `oe` ignored) stores `wdata` at `addr`. Any number of reads and writes are allowed.
- R2: In any cycle that follows no served read, including during reset, `rvalid` is 0 and `rdata` is 0.
- R3: Reset holds `busy` high. After release, an automatic restore keeps `busy` high for exactly 2×DEPTH cycles: DEPTH cycles of clearing, then DEPTH cycles of loading.
- R4: A save or restore is triggered by six reads with `busy` low. The first five are at 0x2A5, 0x15A, 0x0F0, 0x30F and 0x0CC, in that order. The sixth is at 0x333 for a save or 0x1E1 for a restore. Cycles with no access between key reads do not break the sequence. `busy` is high in the cycle after the sixth read.
- R5: A write, or a read at an address other than the expected next key, aborts the sequence. The matcher returns to its first step and no transfer starts.
- R6: A save keeps `busy` high for DEPTH + SETTLE_CYC cycles. Afterwards the shadow array holds the SRAM contents as they were when the save started.
- R7: A restore keeps `busy` high for 2×DEPTH cycles. Afterwards every SRAM word equals its shadow word. The shadow array is left unchanged, so restores can be repeated any number of times.
- R8: While `busy` is high, a read gives `rvalid`=0 in the next cycle, a write changes no word, and neither access affects the matcher.
- R9: Reads that form the key sequence are ordinary reads and return the stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts the automatic restore |
| ce | input | 1 | Chip enable |
| oe | input | 1 | Output enable (read when `we` is low) |
| we | input | 1 | Write enable |
| addr | input | ADDR_W (10) | Word address |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid, one cycle after a served read |
| busy | output | 1 | Transfer in progress |

## Verification
A controller stuck in the wrong state shows up at once as a `busy` interval of the wrong length. The bench measures that interval to the exact cycle for the power-up restore, for saves and for requested restores. A matcher that advances, aborts or fires wrongly shows as `busy` rising, or failing to rise, in the cycle right after the sixth read. A corrupted walk index or a wrong data path during a transfer stays hidden until `busy` falls. It then shows in a full sweep of all words, checked against arithmetic patterns and the bench's own model of the shadow array.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        XF_IDLE,
        XF_STORE_WALK,
        XF_STORE_SETTLE,
        XF_RCL_CLEAR,
        XF_RCL_LOAD
    } xfer_state_e;

    typedef enum logic [2:0] {
        MS_A,
        MS_B,
        MS_C,
        MS_D,
        MS_E,
        MS_F
    } match_state_e;

    localparam int KEY_W = 10;
    localparam logic [KEY_W-1:0] KEY_1       = 10'h2A5;
    localparam logic [KEY_W-1:0] KEY_2       = 10'h15A;
    localparam logic [KEY_W-1:0] KEY_3       = 10'h0F0;
    localparam logic [KEY_W-1:0] KEY_4       = 10'h30F;
    localparam logic [KEY_W-1:0] KEY_5       = 10'h0CC;
    localparam logic [KEY_W-1:0] KEY_SAVE    = 10'h333;
    localparam logic [KEY_W-1:0] KEY_RESTORE = 10'h1E1;

endpackage

// File: rtl/nvs_seq_match.sv
module nvs_seq_match
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    output logic              go_store,
    output logic              go_recall
);

    match_state_e state_q, state_d;
    logic [ADDR_W-1:0] expect_addr;
    logic              hit;

    always_comb begin
        unique case (state_q)
            MS_A:    expect_addr = ADDR_W'(KEY_1);
            MS_B:    expect_addr = ADDR_W'(KEY_2);
            MS_C:    expect_addr = ADDR_W'(KEY_3);
            MS_D:    expect_addr = ADDR_W'(KEY_4);
            MS_E:    expect_addr = ADDR_W'(KEY_5);
            default: expect_addr = '0;
        endcase
    end

    assign hit = rd_stb && !wr_stb && (addr == expect_addr);

    always_comb begin
        state_d = state_q;
        if (wr_stb) begin
            state_d = MS_A;
        end else if (rd_stb) begin
            unique case (state_q)
                MS_A:    state_d = hit ? MS_B : MS_A;
                MS_B:    state_d = hit ? MS_C : MS_A;
                MS_C:    state_d = hit ? MS_D : MS_A;
                MS_D:    state_d = hit ? MS_E : MS_A;
                MS_E:    state_d = hit ? MS_F : MS_A;
                MS_F:    state_d = MS_A;
                default: state_d = MS_A;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_A;
        else        state_q <= state_d;
    end

    always_comb begin
        go_store  = rd_stb && !wr_stb && (state_q == MS_F) && (addr == ADDR_W'(KEY_SAVE));
        go_recall = rd_stb && !wr_stb && (state_q == MS_F) && (addr == ADDR_W'(KEY_RESTORE));
    end

endmodule

// File: rtl/nvs_xfer_ctrl.sv
module nvs_xfer_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_store,
    input  logic              go_recall,
    output logic              busy,
    output logic [ADDR_W-1:0] idx,
    output logic              sram_clr,
    output logic              sram_load,
    output logic              nv_save
);

    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SCNT_LAST = SW'(SETTLE_CYC - 1);

    xfer_state_e       state_q, state_d;
    logic [ADDR_W-1:0] idx_q, idx_d;
    logic [SW-1:0]     scnt_q, scnt_d;
    logic              idx_last;

    assign idx_last = (idx_q == {ADDR_W{1'b1}});

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        scnt_d  = scnt_q;
        unique case (state_q)
            XF_IDLE: begin
                if (go_recall) begin
                    state_d = XF_RCL_CLEAR;
                    idx_d   = '0;
                end else if (go_store) begin
                    state_d = XF_STORE_WALK;
                    idx_d   = '0;
                end
            end
            XF_STORE_WALK: begin
                idx_d = idx_q + 1'b1;
                if (idx_last) begin
                    state_d = XF_STORE_SETTLE;
                    scnt_d  = '0;
                end
            end
            XF_STORE_SETTLE: begin
                scnt_d = scnt_q + 1'b1;
                if (scnt_q == SCNT_LAST) state_d = XF_IDLE;
            end
            XF_RCL_CLEAR: begin
                idx_d = idx_q + 1'b1;
                if (idx_last) state_d = XF_RCL_LOAD;
            end
            XF_RCL_LOAD: begin
                idx_d = idx_q + 1'b1;
                if (idx_last) state_d = XF_IDLE;
            end
            default: state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XF_RCL_CLEAR;
            idx_q   <= '0;
            scnt_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            scnt_q  <= scnt_d;
        end
    end

    always_comb begin
        busy      = (state_q != XF_IDLE);
        sram_clr  = (state_q == XF_RCL_CLEAR);
        sram_load = (state_q == XF_RCL_LOAD);
        nv_save   = (state_q == XF_STORE_WALK);
        idx       = idx_q;
    end

endmodule

// File: rtl/nv_shadow_mem.sv
module nv_shadow_mem #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              oe,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              busy
);

    localparam int DEPTH = 1 << ADDR_W;

    logic              rd_req, wr_req, rd_stb, wr_stb;
    logic              go_store, go_recall;
    logic [ADDR_W-1:0] idx;
    logic              sram_clr, sram_load, nv_save;

    logic [DATA_W-1:0] sram_q [DEPTH];
    logic [DATA_W-1:0] nv_q   [DEPTH];

    assign rd_req = ce && oe && !we;
    assign wr_req = ce && we;
    assign rd_stb = rd_req && !busy;
    assign wr_stb = wr_req && !busy;

    nvs_seq_match #(.ADDR_W(ADDR_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .addr      (addr),
        .go_store  (go_store),
        .go_recall (go_recall)
    );

    nvs_xfer_ctrl #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_store  (go_store),
        .go_recall (go_recall),
        .busy      (busy),
        .idx       (idx),
        .sram_clr  (sram_clr),
        .sram_load (sram_load),
        .nv_save   (nv_save)
    );

    always_ff @(posedge clk) begin
        if (sram_clr)       sram_q[idx]  <= '0;
        else if (sram_load) sram_q[idx]  <= nv_q[idx];
        else if (wr_stb)    sram_q[addr] <= wdata;
        if (nv_save)        nv_q[idx]    <= sram_q[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (rd_stb) begin
            rdata  <= sram_q[addr];
            rvalid <= 1'b1;
        end else begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              oe,
    input logic              we,
    input logic              busy,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic              go_store,
    input logic              go_recall
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MAXRUN = (2 * DEPTH > DEPTH + SETTLE_CYC) ? 2 * DEPTH : DEPTH + SETTLE_CYC;

    logic rd_req;
    logic [31:0] run_len;

    assign rd_req = ce && oe && !we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 32'd0;
        else if (busy) run_len <= run_len + 32'd1;
        else           run_len <= 32'd0;
    end

    assert_served_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !busy) |=> rvalid);

    assert_quiet_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

    assert_trigger_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_store || go_recall) |=> busy);

    assert_single_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_store && go_recall));

    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= MAXRUN);

    assert_blocked_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy) |=> !rvalid);

endmodule

bind nv_shadow_mem nvs_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC)
) u_nvs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (ce),
    .oe        (oe),
    .we        (we),
    .busy      (busy),
    .rvalid    (rvalid),
    .rdata     (rdata),
    .go_store  (go_store),
    .go_recall (go_recall)
);

// File: tb/nv_shadow_mem_test.sv
module nv_shadow_mem_test;

    localparam int AW     = 10;
    localparam int DW     = 8;
    localparam int SETTLE = 4;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b0, oe = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid, busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [DW-1:0] exp_sram [DEPTH];
    logic [DW-1:0] exp_nv   [DEPTH];

    localparam logic [AW-1:0] K1 = 10'h2A5, K2 = 10'h15A, K3 = 10'h0F0,
                              K4 = 10'h30F, K5 = 10'h0CC,
                              KS = 10'h333, KR = 10'h1E1;

    nv_shadow_mem #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .oe(oe), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .busy(busy)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] pat_a(int a);
        return DW'((a * 37 + 11) & 8'hFF);
    endfunction

    function automatic logic [DW-1:0] pat_b(int a);
        return ~pat_a(a);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_read(logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        ce = 1'b1; oe = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        ce = 1'b0; oe = 1'b0;
        d = rdata; v = rvalid;
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
        ce = 1'b1; we = 1'b1; oe = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        ce = 1'b0; we = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 10 * DEPTH) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic fill(bit use_b);
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] v;
            v = use_b ? pat_b(a) : pat_a(a);
            do_write(AW'(a), v);
            exp_sram[a] = v;
        end
    endtask

    task automatic sweep(string req);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] d;
            logic v;
            do_read(AW'(a), d, v);
            if (!v || d !== exp_sram[a]) begin
                bad++;
                if (bad < 4) check(1'b0, req, int'(d), int'(exp_sram[a]));
            end
        end
        check(bad == 0, req, bad, 0);
    endtask

    // five key reads, each checked as an ordinary read (R9)
    task automatic key_prefix(bit gaps);
        logic [AW-1:0] keys [5];
        keys = '{K1, K2, K3, K4, K5};
        for (int i = 0; i < 5; i++) begin
            logic [DW-1:0] d;
            logic v;
            do_read(keys[i], d, v);
            check(v && d === exp_sram[keys[i]], "R9", int'(d), int'(exp_sram[keys[i]]));
            if (gaps) repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                n_chk++;
                $display("FAIL watchdog: actual %0d cycles expected done", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int n;
        logic [DW-1:0] d;
        logic v;

        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R3 busy in reset", int'(busy), 1);
        check(rvalid == 1'b0 && rdata == '0, "R2 reset outputs", int'(rdata), 0);
        rst_n = 1'b1;
        count_busy(n);
        check(n == 2 * DEPTH, "R3 power-up restore length", n, 2 * DEPTH);

        // R1: exhaustive write then read
        fill(1'b0);
        sweep("R1 sweep A");
        @(negedge clk);
        check(rvalid == 1'b0 && rdata == '0, "R2 idle outputs", int'(rdata), 0);

        // R4: save with idle gaps between key reads
        key_prefix(1'b1);
        do_read(KS, d, v);
        check(v && d === exp_sram[KS], "R9 final key read", int'(d), int'(exp_sram[KS]));
        check(busy == 1'b1, "R4 busy after save key", int'(busy), 1);
        for (int a = 0; a < DEPTH; a++) exp_nv[a] = exp_sram[a];
        // R8: accesses while busy
        do_read(AW'(5), d, v);
        check(v == 1'b0 && d == '0, "R8 blocked read", int'(v), 0);
        do_write(AW'(5), ~pat_a(5));
        count_busy(n);
        check(n + 2 == DEPTH + SETTLE, "R6 save length", n + 2, DEPTH + SETTLE);
        do_read(AW'(5), d, v);
        check(v && d === pat_a(5), "R8 write ignored", int'(d), int'(pat_a(5)));

        // overwrite SRAM with B
        fill(1'b1);

        // R5 (a): write inside the sequence aborts
        key_prefix(1'b0);
        do_write(AW'(7), 8'h5A);
        exp_sram[7] = 8'h5A;
        do_read(KS, d, v);
        @(negedge clk);
        check(busy == 1'b0, "R5 abort by write", int'(busy), 0);

        // R5 (b): wrong address in the middle aborts
        do_read(K1, d, v);
        do_read(K2, d, v);
        do_read(AW'(3), d, v);
        do_read(K3, d, v);
        do_read(K4, d, v);
        do_read(K5, d, v);
        do_read(KR, d, v);
        check(busy == 1'b0, "R5 abort by wrong read", int'(busy), 0);

        // R5 (c): unknown sixth address starts nothing
        key_prefix(1'b0);
        do_read(AW'(9), d, v);
        check(busy == 1'b0, "R5 bad final key", int'(busy), 0);
        sweep("R5 data kept after aborts");

        // R7: restore
        key_prefix(1'b0);
        do_read(KR, d, v);
        check(busy == 1'b1, "R4 busy after restore key", int'(busy), 1);
        count_busy(n);
        check(n == 2 * DEPTH, "R7 restore length", n, 2 * DEPTH);
        for (int a = 0; a < DEPTH; a++) exp_sram[a] = exp_nv[a];
        sweep("R7 restored A");

        // R7: repeat restore, shadow unchanged
        do_write(AW'(100), 8'h00);
        do_write(AW'(1023), 8'hEE);
        key_prefix(1'b0);
        do_read(KR, d, v);
        count_busy(n);
        check(n == 2 * DEPTH, "R7 second restore length", n, 2 * DEPTH);
        sweep("R7 repeated restore");

        // R6: second save of pattern B, then restore proves snapshot
        fill(1'b1);
        key_prefix(1'b0);
        do_read(KS, d, v);
        for (int a = 0; a < DEPTH; a++) exp_nv[a] = exp_sram[a];
        count_busy(n);
        check(n == DEPTH + SETTLE, "R6 second save length", n, DEPTH + SETTLE);
        fill(1'b0);
        key_prefix(1'b0);
        do_read(KR, d, v);
        count_busy(n);
        for (int a = 0; a < DEPTH; a++) exp_sram[a] = exp_nv[a];
        sweep("R6 snapshot B restored");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule